// File: doc/BRIEF.md
# Sticky Limit-Status Interrupt Controller

This block compares each of fifteen monitored channels against its own upper and lower limit whenever that channel reports a fresh measurement. It records each out-of-window result in one of two 8-bit status registers. A status bit is sticky: it stays set after the measurement comes back inside its window. Only a read of its register can clear it, and the read clears it only when the channel's most recent comparison was in range. The block drives an active-low alert pin from the status bits that software has not masked.

Software either polls the two status registers over a simple register port or waits for the alert. The top bit of the first status register is a summary of the second, so a single read shows whether the second register also needs attention. Fan-speed channels and analog channels strobe independently of each other. Any combination of strobes can arrive in the same cycle.

Top module: `limit_irq_ctrl`

## Requirements
- R1: A strobed measurement sets its channel's status bit in the next cycle when the value is strictly above the high limit or strictly below the low limit. A value equal to either limit counts as in range and sets nothing.
- R2: A set status bit stays set while its register is not read, whatever later measurements on that channel report.
- R3: Reading a status register clears each set bit whose channel's latest completed comparison was in range. The comparison in question is the one recorded by strobes in earlier cycles. The cleared value is visible from the next cycle.
- R4: A read leaves a set bit unchanged when its channel's latest comparison was still out of range.
- R5: The status registers sit at address 0x41 and address 0x42. Address 0x41 bits 6..0 hold channels 6..0. Address 0x42 bits 7..0 hold channels 14..7. Read data is valid in the cycle the read strobe is high and shows the value before any clearing. Unmapped addresses read 0x00.
- R6: Bit 7 at address 0x41 reads 1 exactly when any bit at address 0x42 is set. Reading address 0x41 never clears anything at address 0x42.
- R7: The alert output is low while any status bit is set and its mask bit is 0, and high otherwise. The mask register at 0x74 bits 6..0 covers channels 6..0, and its bit 7 has no effect on the alert. The mask register at 0x75 covers channels 14..7 bit for bit.
- R8: A masked channel still sets its status bit when it goes out of range.
- R9: When a set event and a clearing read reach the same bit in the same cycle, the bit ends up set.
- R10: After reset, both status registers and both mask registers read 0x00 and the alert output is high.
- R11: Both mask registers are read/write. Writes to the status register addresses change nothing.
- R12: Strobes on several channels in the same cycle each take effect independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_vld | input | 15 | Per-channel strobe, new measurement present |
| meas_val | input | 15*DW | Measured values, channel i at [i*DW +: DW] |
| hi_lim | input | 15*DW | Upper limits, same packing |
| lo_lim | input | 15*DW | Lower limits, same packing |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| alert_n | output | 1 | Active-low alert |

## Verification
The bench builds the block with DW = 10, which is wider than the default of 8. The limits are 600 and 100, so out-of-range values such as 601 and 1023 exist only above the 8-bit range. These limits put the exact boundary values and the full-scale codes 0 and 1023 within reach of the table walk. That walk covers both registers. Directed cases then check a same-cycle read and set event on one bit, a read while the condition persists, the summary bit tracking register 2, and the masking of a channel whose status bit still sets.

// File: rtl/lim_irq_pkg.sv
package lim_irq_pkg;
  localparam int NCH  = 15;
  localparam int N1   = 7;
  localparam int N2   = NCH - N1;
  localparam int REGW = 8;
  localparam logic [7:0] ADDR_ST1 = 8'h41;
  localparam logic [7:0] ADDR_ST2 = 8'h42;
  localparam logic [7:0] ADDR_MK1 = 8'h74;
  localparam logic [7:0] ADDR_MK2 = 8'h75;
endpackage

// File: rtl/window_cmp.sv
module window_cmp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic [DW-1:0] val,
  input  logic [DW-1:0] hi,
  input  logic [DW-1:0] lo,
  output logic          set_ev,
  output logic          cond
);
  logic oor;
  logic cond_d;

  assign oor    = (val > hi) || (val < lo);
  assign set_ev = vld & oor;

  always_comb begin
    cond_d = cond;
    if (vld) cond_d = oor;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond <= 1'b0;
    else        cond <= cond_d;
  end

  // R1
  cond_tracks_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && (val > hi)) |=> cond);
endmodule

// File: rtl/status_bank.sv
module status_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_ev,
  input  logic [W-1:0] cond,
  input  logic         rd_clr,
  output logic [W-1:0] st
);
  logic [W-1:0] st_d;
  logic [W-1:0] clr_mask;

  assign clr_mask = rd_clr ? ~cond : '0;

  always_comb begin
    st_d = (st & ~clr_mask) | set_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= st_d;
  end

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((st & $past(st)) == $past(st)));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st & $past(set_ev)) == $past(set_ev)));

  // R4
  persist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> ((st & $past(st & cond)) == $past(st & cond)));
endmodule

// File: rtl/alert_gen.sv
module alert_gen #(
  parameter int N = 15
) (
  input  logic [N-1:0] st,
  input  logic [N-1:0] msk,
  output logic         alert_n
);
  assign alert_n = ~|(st & ~msk);
endmodule

// File: rtl/limit_irq_ctrl.sv
module limit_irq_ctrl
  import lim_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    meas_vld,
  input  logic [NCH*DW-1:0] meas_val,
  input  logic [NCH*DW-1:0] hi_lim,
  input  logic [NCH*DW-1:0] lo_lim,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              alert_n
);
  logic [NCH-1:0]  set_ev;
  logic [NCH-1:0]  cond;
  logic [N1-1:0]   st1;
  logic [N2-1:0]   st2;
  logic [REGW-1:0] mk1, mk1_d;
  logic [REGW-1:0] mk2, mk2_d;
  logic            rd_st1, rd_st2;
  logic [NCH-1:0]  st_all, mk_all;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    window_cmp #(.DW(DW)) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .vld   (meas_vld[i]),
      .val   (meas_val[i*DW +: DW]),
      .hi    (hi_lim[i*DW +: DW]),
      .lo    (lo_lim[i*DW +: DW]),
      .set_ev(set_ev[i]),
      .cond  (cond[i])
    );
  end

  assign rd_st1 = bus_rd && (bus_addr == ADDR_ST1);
  assign rd_st2 = bus_rd && (bus_addr == ADDR_ST2);

  status_bank #(.W(N1)) u_bank1 (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev[N1-1:0]), .cond(cond[N1-1:0]),
    .rd_clr(rd_st1), .st(st1)
  );

  status_bank #(.W(N2)) u_bank2 (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev[NCH-1:N1]), .cond(cond[NCH-1:N1]),
    .rd_clr(rd_st2), .st(st2)
  );

  always_comb begin
    mk1_d = mk1;
    mk2_d = mk2;
    if (bus_wr && (bus_addr == ADDR_MK1)) mk1_d = bus_wdata;
    if (bus_wr && (bus_addr == ADDR_MK2)) mk2_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mk1 <= '0;
      mk2 <= '0;
    end else begin
      mk1 <= mk1_d;
      mk2 <= mk2_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        ADDR_ST1: bus_rdata = {|st2, st1};
        ADDR_ST2: bus_rdata = st2;
        ADDR_MK1: bus_rdata = mk1;
        ADDR_MK2: bus_rdata = mk2;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign st_all = {st2, st1};
  assign mk_all = {mk2, mk1[N1-1:0]};

  alert_gen #(.N(NCH)) u_alert (
    .st     (st_all),
    .msk    (mk_all),
    .alert_n(alert_n)
  );

  // R7
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mk_all) |-> alert_n);

  // R11
  status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && (meas_vld == '0)) |=> (st_all == $past(st_all)));
endmodule

// File: tb/limit_irq_ctrl_test.sv
module limit_irq_ctrl_test;
  localparam int DW  = 10;
  localparam int NCH = 15;
  localparam int HI  = 600;
  localparam int LO  = 100;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NCH-1:0]    meas_vld;
  logic [NCH*DW-1:0] meas_val, hi_lim, lo_lim;
  logic              bus_wr, bus_rd;
  logic [7:0]        bus_addr, bus_wdata;
  logic [7:0]        bus_rdata;
  logic              alert_n;

  int tests = 0;
  int fails = 0;

  limit_irq_ctrl #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .meas_vld(meas_vld), .meas_val(meas_val),
    .hi_lim(hi_lim), .lo_lim(lo_lim), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alert_n(alert_n)
  );

  always #10 clk = ~clk;

  // {channel[3:0], value[9:0], expected status}
  localparam logic [14:0] VEC [0:7] = '{
    {4'd0,  10'd601,  1'b1},
    {4'd1,  10'd600,  1'b0},
    {4'd6,  10'd100,  1'b0},
    {4'd7,  10'd99,   1'b1},
    {4'd9,  10'd0,    1'b1},
    {4'd14, 10'd1023, 1'b1},
    {4'd12, 10'd300,  1'b0},
    {4'd3,  10'd700,  1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic meas(input int ch, input int v);
    meas_vld[ch] = 1'b1;
    meas_val[ch*DW +: DW] = v[DW-1:0];
    @(negedge clk);
    meas_vld = '0;
  endtask

  task automatic rd(input logic [7:0] a, input string req, input logic [7:0] exp);
    bus_rd = 1'b1;
    bus_addr = a;
    #2;
    check(req, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_wr = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  function automatic logic [7:0] reg_of(input int ch);
    return (ch < 7) ? 8'h41 : 8'h42;
  endfunction

  function automatic logic [7:0] bit_of(input int ch, input logic b);
    return (ch < 7) ? ({7'd0, b} << ch) : ({7'd0, b} << (ch - 7));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    meas_vld = '0;
    meas_val = '0;
    bus_wr = 1'b0;
    bus_rd = 1'b0;
    bus_addr = '0;
    bus_wdata = '0;
    for (int i = 0; i < NCH; i++) begin
      hi_lim[i*DW +: DW] = DW'(HI);
      lo_lim[i*DW +: DW] = DW'(LO);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 alert", {7'd0, alert_n}, 8'h01);
    rd(8'h41, "R10 st1", 8'h00);
    rd(8'h42, "R10 st2", 8'h00);
    rd(8'h74, "R10 mk1", 8'h00);
    rd(8'h75, "R10 mk2", 8'h00);

    // R1 R2 R3 R5 table walk
    for (int k = 0; k < 8; k++) begin
      int ch;
      int v;
      logic e;
      ch = int'(VEC[k][14:11]);
      v  = int'(VEC[k][10:1]);
      e  = VEC[k][0];
      meas(ch, v);
      if (e) begin
        check("R7 alert low", {7'd0, alert_n}, 8'h00);
      end
      rd(reg_of(ch) == 8'h42 ? 8'h42 : 8'h41, "R1/R5 set",
         bit_of(ch, e) | ((ch >= 7 && e) ? 8'h00 : 8'h00));
      meas(ch, 300);
      rd(reg_of(ch), "R2 sticky", bit_of(ch, e));
      rd(reg_of(ch), "R3 cleared", 8'h00);
      check("R7 alert released", {7'd0, alert_n}, 8'h01);
    end

    // R4 persisting condition
    meas(3, 700);
    rd(8'h41, "R4 first read", 8'h08);
    rd(8'h41, "R4 still set", 8'h08);
    meas(3, 300);
    rd(8'h41, "R3 clear ch3", 8'h08);
    rd(8'h41, "R3 ch3 gone", 8'h00);

    // R6 summary
    meas(10, 50);
    rd(8'h41, "R6 summary", 8'h80);
    rd(8'h41, "R6 summary repeat", 8'h80);
    meas(10, 300);
    rd(8'h42, "R6 st2 kept", 8'h08);
    rd(8'h41, "R6 summary clear", 8'h00);

    // R8 R7 masking
    wr(8'h75, 8'h08);
    rd(8'h75, "R11 mk2 readback", 8'h08);
    meas(10, 900);
    check("R8 masked alert high", {7'd0, alert_n}, 8'h01);
    wr(8'h75, 8'h00);
    check("R7 unmasked alert low", {7'd0, alert_n}, 8'h00);
    wr(8'h74, 8'h80);
    rd(8'h74, "R11 mk1 readback", 8'h80);
    check("R7 mk1 bit7 no effect", {7'd0, alert_n}, 8'h00);
    meas(10, 300);
    rd(8'h42, "R8 masked bit set", 8'h08);
    rd(8'h42, "R8 cleared", 8'h00);
    wr(8'h74, 8'h00);

    // R11 status writes ignored
    wr(8'h41, 8'hFF);
    wr(8'h42, 8'hFF);
    rd(8'h41, "R11 st1 write", 8'h00);
    rd(8'h42, "R11 st2 write", 8'h00);
    check("R11 alert", {7'd0, alert_n}, 8'h01);

    // R9 set beats clear
    meas(0, 700);
    meas(0, 300);
    bus_rd = 1'b1;
    bus_addr = 8'h41;
    meas_vld[0] = 1'b1;
    meas_val[0 +: DW] = DW'(800);
    #2;
    check("R9 pre value", bus_rdata, 8'h01);
    @(negedge clk);
    bus_rd = 1'b0;
    meas_vld = '0;
    rd(8'h41, "R9 set wins", 8'h01);
    meas(0, 300);
    rd(8'h41, "R9 clear", 8'h01);
    rd(8'h41, "R9 cleared", 8'h00);

    // R12 simultaneous strobes
    meas_vld[2] = 1'b1;
    meas_val[2*DW +: DW] = DW'(1000);
    meas_vld[8] = 1'b1;
    meas_val[8*DW +: DW] = DW'(20);
    meas_vld[5] = 1'b1;
    meas_val[5*DW +: DW] = DW'(400);
    @(negedge clk);
    meas_vld = '0;
    rd(8'h41, "R12 analog", 8'h84);
    rd(8'h42, "R12 fan", 8'h02);

    // R5 unmapped address
    rd(8'h43, "R5 unmapped", 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule